// File: doc/BRIEF.md
# Program Counter Sequencer with Branch Decision

This block holds the instruction address of a single-cycle processor and picks the next address on every clock. Three control bits from the instruction decoder choose among stepping to the next word, loading an absolute target taken from a register value, and a conditional relative move. The relative move is taken only when a test on the supplied register value succeeds: either its sign bit is set or all of its bits are zero.

The relative displacement comes in as two 3-bit instruction fields. The upper field supplies the high half. Together they form a 6-bit two's-complement number that is widened to the address width before it is added. All address arithmetic wraps at the address width. The current address is the only output, and the instruction memory reads it directly.

Top module: `pc_seq_ctrl`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `pc_q` becomes 0 after that edge, whatever the other inputs are.
- R2: With `ld_en` = 0, `pc_q` advances by one on each edge. `jmp_sel`, `cond_sel`, the displacement fields and `src_a` have no effect.
- R3: With `ld_en` = 1 and `jmp_sel` = 1, `pc_q` takes the value of `src_a` on the next edge.
- R4: With `ld_en` = 1, `jmp_sel` = 0 and `cond_sel` = 1, the sign test applies. The move is taken when `src_a[15]` is 1, and `pc_q` becomes `pc_q` plus the displacement. Otherwise `pc_q` advances by one.
- R5: With `ld_en` = 1, `jmp_sel` = 0 and `cond_sel` = 0, the zero test applies. The move is taken when all 16 bits of `src_a` are 0, and `pc_q` becomes `pc_q` plus the displacement. Otherwise `pc_q` advances by one.
- R6: The displacement is {`ofs_hi`, `ofs_lo`}, read as a 6-bit two's-complement value (-32..31) and sign-extended to 16 bits. For example, from address 45 a taken move with fields 110 and 100 (-12) gives 33.
- R7: All next-address arithmetic wraps modulo 2^16. Stepping from 0xFFFF gives 0, and a negative displacement below 0 wraps to the top of the range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | 0: step by one; 1: jump or conditional move |
| jmp_sel | input | 1 | With ld_en=1: 1 loads src_a, 0 selects the conditional move |
| cond_sel | input | 1 | Conditional test: 1 sign of src_a, 0 src_a all zero |
| ofs_hi | input | 3 | Upper three bits of the displacement |
| ofs_lo | input | 3 | Lower three bits of the displacement |
| src_a | input | 16 | Register value used as jump target and as test operand |
| pc_q | output | 16 | Current program address |

## Verification
The step case is driven under all four combinations of the ignored select bits, with arbitrary register values. This separates true "don't care" handling from a decode that leaks `jmp_sel` or `cond_sel`. Both conditional tests are swept over all 64 displacements in their taken and not-taken forms. The not-taken zero test uses a register value with a single set bit that walks through all 16 positions, so a zero detector that misses any bit shows up. Jumps to 0xFFFF followed by steps, and large negative moves from low addresses, exercise the wrap. The worked example (45 minus 12) pins down the high-first field order and the sign extension.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [1:0] {
      NXT_STEP = 2'd0,
      NXT_JUMP = 2'd1,
      NXT_REL  = 2'd2
   } nxt_src_e;

endpackage

// File: rtl/pcs_status.sv
module pcs_status #(
   parameter int unsigned WORD_W = 16
) (
   input  logic [WORD_W-1:0] value,
   output logic              is_neg,
   output logic              is_zero
);

   initial begin
      if (WORD_W < 2) $error("pcs_status: WORD_W must be at least 2");
   end

   assign is_neg  = value[WORD_W-1];
   assign is_zero = (value == '0);

endmodule

// File: rtl/pcs_ofs_ext.sv
module pcs_ofs_ext #(
   parameter int unsigned HI_W  = 3,
   parameter int unsigned LO_W  = 3,
   parameter int unsigned OUT_W = 16
) (
   input  logic [HI_W-1:0]  fld_hi,
   input  logic [LO_W-1:0]  fld_lo,
   output logic [OUT_W-1:0] ext
);

   localparam int unsigned RAW_W = HI_W + LO_W;
   localparam int unsigned PAD_W = OUT_W - RAW_W;

   initial begin
      if (HI_W < 1 || LO_W < 1) $error("pcs_ofs_ext: field widths must be nonzero");
      if (OUT_W <= RAW_W) $error("pcs_ofs_ext: output must be wider than the joined field");
   end

   logic [RAW_W-1:0] raw;

   assign raw = {fld_hi, fld_lo};
   assign ext = {{PAD_W{raw[RAW_W-1]}}, raw};

endmodule

// File: rtl/pcs_next_sel.sv
module pcs_next_sel
   import pcs_pkg::*;
#(
   parameter int unsigned PC_W         = 16,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic [PC_W-1:0] pc_cur,
   input  logic [PC_W-1:0] tgt,
   input  logic [PC_W-1:0] disp,
   input  logic            ld_en,
   input  logic            jmp_sel,
   input  logic            cond_sel,
   input  logic            is_neg,
   input  logic            is_zero,
   output logic [PC_W-1:0] pc_nxt
);

   localparam logic [PC_W-1:0] ONE = PC_W'(1);

   nxt_src_e src;
   logic     cond_hit;

   assign cond_hit = cond_sel ? is_neg : is_zero;

   always_comb begin
      if (!ld_en)        src = NXT_STEP;
      else if (jmp_sel)  src = NXT_JUMP;
      else if (cond_hit) src = NXT_REL;
      else               src = NXT_STEP;
   end

   generate
      if (SHARED_ADDER) begin : g_one_adder
         logic [PC_W-1:0] addend;
         logic [PC_W-1:0] sum;
         assign addend = (src == NXT_REL) ? disp : ONE;
         assign sum    = pc_cur + addend;
         assign pc_nxt = (src == NXT_JUMP) ? tgt : sum;
      end else begin : g_two_adders
         logic [PC_W-1:0] inc_v;
         logic [PC_W-1:0] rel_v;
         assign inc_v = pc_cur + ONE;
         assign rel_v = pc_cur + disp;
         always_comb begin
            unique case (src)
               NXT_JUMP: pc_nxt = tgt;
               NXT_REL:  pc_nxt = rel_v;
               default:  pc_nxt = inc_v;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl #(
   parameter int unsigned PC_W         = 16,
   parameter int unsigned OFS_HI_W     = 3,
   parameter int unsigned OFS_LO_W     = 3,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ld_en,
   input  logic                jmp_sel,
   input  logic                cond_sel,
   input  logic [OFS_HI_W-1:0] ofs_hi,
   input  logic [OFS_LO_W-1:0] ofs_lo,
   input  logic [PC_W-1:0]     src_a,
   output logic [PC_W-1:0]     pc_q
);

   localparam int unsigned OFS_W = OFS_HI_W + OFS_LO_W;

   initial begin
      if (PC_W < 2) $error("pc_seq_ctrl: PC_W too small");
      if (OFS_W >= PC_W) $error("pc_seq_ctrl: displacement must be narrower than PC");
   end

   logic            neg_w;
   logic            zero_w;
   logic [PC_W-1:0] disp_w;
   logic [PC_W-1:0] nxt_w;

   pcs_status #(.WORD_W(PC_W)) u_status (
      .value   (src_a),
      .is_neg  (neg_w),
      .is_zero (zero_w)
   );

   pcs_ofs_ext #(.HI_W(OFS_HI_W), .LO_W(OFS_LO_W), .OUT_W(PC_W)) u_ext (
      .fld_hi (ofs_hi),
      .fld_lo (ofs_lo),
      .ext    (disp_w)
   );

   pcs_next_sel #(.PC_W(PC_W), .SHARED_ADDER(SHARED_ADDER)) u_sel (
      .pc_cur   (pc_q),
      .tgt      (src_a),
      .disp     (disp_w),
      .ld_en    (ld_en),
      .jmp_sel  (jmp_sel),
      .cond_sel (cond_sel),
      .is_neg   (neg_w),
      .is_zero  (zero_w),
      .pc_nxt   (nxt_w)
   );

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= nxt_w;
   end

   // R1
   p_reset_zero_r1: assert property (@(posedge clk) rst |=> pc_q == '0);

   // R2 and R7: stepping wraps
   p_step_r2: assert property (@(posedge clk) disable iff (rst)
      !ld_en |=> pc_q == PC_W'($past(pc_q) + 1'b1));

   // R3
   p_jump_r3: assert property (@(posedge clk) disable iff (rst)
      (ld_en && jmp_sel) |=> pc_q == $past(src_a));

   // R4: sign test fails, so the address steps
   p_sign_miss_r4: assert property (@(posedge clk) disable iff (rst)
      (ld_en && !jmp_sel && cond_sel && !src_a[PC_W-1]) |=> pc_q == PC_W'($past(pc_q) + 1'b1));

   // R5: zero test fails, so the address steps
   p_zero_miss_r5: assert property (@(posedge clk) disable iff (rst)
      (ld_en && !jmp_sel && !cond_sel && src_a != '0) |=> pc_q == PC_W'($past(pc_q) + 1'b1));

endmodule

// File: tb/pc_seq_ctrl_test.sv
module pc_seq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst;
   logic        ld_en, jmp_sel, cond_sel;
   logic [2:0]  ofs_hi, ofs_lo;
   logic [15:0] src_a;
   logic [15:0] pc_q;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [15:0] model = 16'h0;

   always #5 clk = ~clk;

   pc_seq_ctrl uut (
      .clk(clk), .rst(rst), .ld_en(ld_en), .jmp_sel(jmp_sel), .cond_sel(cond_sel),
      .ofs_hi(ofs_hi), .ofs_lo(ofs_lo), .src_a(src_a), .pc_q(pc_q)
   );

   task automatic compare(input logic [15:0] exp, input string tag);
      n_vec++;
      if (pc_q !== exp) begin
         n_fail++;
         $display("FAIL %s: pc_q=%h expected %h", tag, pc_q, exp);
      end
   endtask

   task automatic step(input logic l, input logic j, input logic c,
                       input logic [2:0] h, input logic [2:0] lo,
                       input logic [15:0] a, input string tag);
      logic [15:0] disp;
      logic        hit;
      logic [15:0] exp;
      disp = {{10{h[2]}}, h, lo};
      hit  = c ? a[15] : (a == 16'h0);
      if (!l)      exp = model + 16'd1;
      else if (j)  exp = a;
      else if (hit) exp = model + disp;
      else         exp = model + 16'd1;
      ld_en = l; jmp_sel = j; cond_sel = c; ofs_hi = h; ofs_lo = lo; src_a = a;
      @(posedge clk); #1;
      compare(exp, tag);
      model = exp;
   endtask

   task automatic do_reset(input string tag);
      rst = 1'b1; ld_en = 1'b1; jmp_sel = 1'b1; src_a = 16'hBEEF;
      @(posedge clk); #1;
      compare(16'h0, tag);
      rst = 1'b0;
      model = 16'h0;
   endtask

   initial begin
      rst = 1'b1; ld_en = 0; jmp_sel = 0; cond_sel = 0;
      ofs_hi = 0; ofs_lo = 0; src_a = 0;
      @(posedge clk); #1;
      do_reset("R1 initial");

      // R2: step ignores the other controls
      for (int k = 0; k < 32; k++)
         step(1'b0, k[0], k[1], k[4:2], k[2:0], 16'h1234 * k[4:0], "R2 step");

      // R3: jumps to assorted targets
      for (int k = 0; k < 16; k++)
         step(1'b1, 1'b1, k[0], 3'd5, 3'd2, 16'h0F0F ^ (16'd1 << k), "R3 jump");
      step(1'b1, 1'b1, 1'b0, 3'd0, 3'd0, 16'h0000, "R3 jump zero");

      // R4: sign test, taken and not taken, every displacement
      for (int k = 0; k < 64; k++) begin
         step(1'b1, 1'b0, 1'b1, k[5:3], k[2:0], 16'h8000 | 16'(k), "R4 sign taken");
         step(1'b1, 1'b0, 1'b1, k[5:3], k[2:0], 16'h7FFF - 16'(k), "R4 sign miss");
      end

      // R5: zero test, taken and not taken with a walking one
      for (int k = 0; k < 64; k++) begin
         step(1'b1, 1'b0, 1'b0, k[5:3], k[2:0], 16'h0000, "R5 zero taken");
         step(1'b1, 1'b0, 1'b0, k[5:3], k[2:0], 16'd1 << (k % 16), "R5 zero miss");
      end

      // R6: worked example 45 - 12 = 33
      step(1'b1, 1'b1, 1'b0, 3'd0, 3'd0, 16'd45, "R6 set 45");
      step(1'b1, 1'b0, 1'b0, 3'b110, 3'b100, 16'h0000, "R6 45-12");
      compare(16'd33, "R6 literal 33");
      step(1'b1, 1'b0, 1'b1, 3'b011, 3'b111, 16'hFFFF, "R6 +31");
      compare(16'd64, "R6 literal 64");

      // R7: wrap forward and backward
      step(1'b1, 1'b1, 1'b0, 3'd0, 3'd0, 16'hFFFE, "R7 set FFFE");
      step(1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0, "R7 step FFFF");
      step(1'b0, 1'b1, 1'b1, 3'd0, 3'd0, 16'h0, "R7 step wrap");
      compare(16'h0000, "R7 literal 0");
      step(1'b1, 1'b0, 1'b0, 3'b100, 3'b000, 16'h0, "R7 back -32");
      compare(16'hFFE0, "R7 literal FFE0");
      step(1'b1, 1'b0, 1'b1, 3'b011, 3'b111, 16'h8001, "R7 fwd wrap");
      compare(16'hFFFF, "R7 literal FFFF");
      step(1'b1, 1'b0, 1'b1, 3'b000, 3'b010, 16'hC000, "R7 +2 wrap");
      compare(16'h0001, "R7 literal 0001");

      // R1: reset mid-run overrides a jump
      do_reset("R1 mid-run");
      step(1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0, "R1 step after reset");

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: run hung, actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule